// File: doc/BRIEF.md
# Segmented Address Generator with Wraparound Gate

This unit forms physical addresses for a legacy 16-bit segmented addressing mode. It holds four 16-bit segment registers (code, data, stack, extra). A select input picks one of them. The unit shifts the chosen value left by four bits and adds an unsigned 16-bit offset. The sum is 21 bits wide, because a large segment plus a large offset can carry past the 1 MB boundary.

A gate register decides what happens to that carry bit (bit 20):
- When the gate is closed, bit 20 is forced to zero, so the address wraps back into low memory.
- When the gate is open, bit 20 passes through, and the unit raises a flag for accesses into the area just above 1 MB.

The address is driven combinationally from the current register contents onto a 24-bit bus. Segment writes and gate writes take effect at the next clock edge.

Top module: `segaddr_unit`

## Requirements
- R1: With the gate open, `phys_addr[20:0]` equals the selected segment times 16 plus the offset. The offset is unsigned and is never sign-extended.
- R2: With segment 0x07C0 and offset 0x0007, `phys_addr` is 0x007C07.
- R3: With the gate open, segment 0xFFFF and offset 0xFFFF give `phys_addr` 0x10FFEF.
- R4: With the gate closed, bit 20 of the 21-bit sum is forced to zero, so 0xFFFF:0xFFFF gives 0x00FFEF.
- R5: `hma_hit` is high exactly when the gate is open and the sum lies in 0x100000 to 0x10FFEF, which is the same as `phys_addr[20]` being set.
- R6: `seg_sel` picks the register used: 0 is code, 1 is data, 2 is stack, 3 is extra.
- R7: When `seg_wr_en` is high at a clock edge, the register at index `seg_wr_idx` (same encoding as R6) takes `seg_wr_data`. The new value is used from that edge on, and the other three registers keep their values.
- R8: After reset, the code segment holds 0xFFFF, the other three hold 0x0000, and the gate is closed.
- R9: When `gate_wr_en` is high at a clock edge, the gate takes `gate_wr_val` (1 = open). Otherwise the gate holds its value, and `gate_wr_val` has no effect.
- R10: `phys_addr[23:21]` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_idx | input | 2 | Segment register to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | New segment value |
| gate_wr_en | input | 1 | Gate register write strobe |
| gate_wr_val | input | 1 | New gate state, 1 = bit 20 passes |
| seg_sel | input | 2 | Segment register used for the address |
| offset | input | 16 | Unsigned offset within the segment |
| phys_addr | output | 24 | Physical address |
| hma_hit | output | 1 | Access lies above 1 MB with the gate open |

## Verification
The address is combinational from the register state, so any corruption shows on `phys_addr` the cycle it happens:
- A register that loaded the wrong value, or that a write to another index disturbed, gives a wrong base as soon as it is selected with offset zero.
- A stuck or wrongly reset gate shows on the first operand pair whose sum carries into bit 20: the address and `hma_hit` are then both wrong together.
- A truncated or sign-extended offset appears on any vector with offset bit 15 set.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;
  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_STACK = 2'd2,
    SEG_EXTRA = 2'd3
  } seg_id_e;

  localparam logic [15:0] CODE_SEG_RESET  = 16'hFFFF;
  localparam logic [15:0] OTHER_SEG_RESET = 16'h0000;
endpackage

// File: rtl/segaddr_regfile.sv
module segaddr_regfile #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  localparam int IDX_W = $clog2(NSEG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEG_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEG_W-1:0] rd_data
);
  import segaddr_pkg::*;

  logic [SEG_W-1:0] seg_q [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    localparam logic [SEG_W-1:0] RST_VAL =
      (i == int'(SEG_CODE)) ? SEG_W'(CODE_SEG_RESET) : SEG_W'(OTHER_SEG_RESET);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        seg_q[i] <= RST_VAL;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        seg_q[i] <= wr_data;
    end
  end

  assign rd_data = seg_q[rd_idx];
endmodule

// File: rtl/segaddr_adder.sv
module segaddr_adder #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  localparam int BASE_W = SEG_W + SHIFT,
  localparam int SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [SUM_W-1:0] sum
);
  function automatic logic [SUM_W-1:0] form_sum(input logic [SEG_W-1:0] s,
                                                 input logic [OFF_W-1:0] o);
    logic [SUM_W-1:0] base;
    base = SUM_W'(s) << SHIFT;
    return base + SUM_W'(o);
  endfunction

  assign sum = form_sum(seg, off);
endmodule

// File: rtl/segaddr_gate.sv
module segaddr_gate #(
  parameter int SUM_W = 21,
  parameter int BUS_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_val,
  input  logic [SUM_W-1:0] sum,
  output logic             gate_q,
  output logic [BUS_W-1:0] phys,
  output logic             hma
);
  localparam logic [SUM_W-1:0] CARRY_BIT = SUM_W'(1) << (SUM_W - 1);

  logic [SUM_W-1:0] masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gate_q <= 1'b0;
    else if (wr_en)
      gate_q <= wr_val;
  end

  always_comb begin
    masked = gate_q ? sum : (sum & ~CARRY_BIT);
    phys   = BUS_W'(masked);
    hma    = masked[SUM_W-1];
  end
endmodule

// File: rtl/segaddr_unit.sv
module segaddr_unit #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG  = 4,
  parameter int BUS_W = 24,
  localparam int IDX_W  = $clog2(NSEG),
  localparam int BASE_W = SEG_W + SHIFT,
  localparam int SUM_W  = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_wr_en,
  input  logic [IDX_W-1:0] seg_wr_idx,
  input  logic [SEG_W-1:0] seg_wr_data,
  input  logic             gate_wr_en,
  input  logic             gate_wr_val,
  input  logic [IDX_W-1:0] seg_sel,
  input  logic [OFF_W-1:0] offset,
  output logic [BUS_W-1:0] phys_addr,
  output logic             hma_hit
);
  logic [SEG_W-1:0] sel_seg;
  logic [SUM_W-1:0] raw_sum;
  logic             gate_q;

  segaddr_regfile #(.SEG_W(SEG_W), .NSEG(NSEG)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(seg_wr_en), .wr_idx(seg_wr_idx), .wr_data(seg_wr_data),
    .rd_idx(seg_sel), .rd_data(sel_seg)
  );

  segaddr_adder #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) add_i (
    .seg(sel_seg), .off(offset), .sum(raw_sum)
  );

  segaddr_gate #(.SUM_W(SUM_W), .BUS_W(BUS_W)) gate_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(gate_wr_en), .wr_val(gate_wr_val),
    .sum(raw_sum), .gate_q(gate_q),
    .phys(phys_addr), .hma(hma_hit)
  );
endmodule

// File: rtl/segaddr_unit_chk.sv
module segaddr_unit_chk #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int IDX_W = 2,
  parameter int SUM_W = 21,
  parameter int BUS_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seg_wr_en,
  input logic [IDX_W-1:0] seg_wr_idx,
  input logic [SEG_W-1:0] seg_wr_data,
  input logic             gate_wr_en,
  input logic             gate_wr_val,
  input logic [IDX_W-1:0] seg_sel,
  input logic [OFF_W-1:0] offset,
  input logic [BUS_W-1:0] phys_addr,
  input logic             hma_hit,
  input logic [SEG_W-1:0] sel_seg,
  input logic [SUM_W-1:0] raw_sum,
  input logic             gate_q
);
  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[BUS_W-1:SUM_W] == '0);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> !phys_addr[SUM_W-1]);

  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> phys_addr[SUM_W-1:0] == raw_sum);

  p_hma_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hma_hit |-> (gate_q && phys_addr[SUM_W-1]));

  p_no_shrink_r1: assert property (@(posedge clk) disable iff (!rst_n)
    gate_q |-> phys_addr[SUM_W-1:0] >= SUM_W'(offset));

  p_seg_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_wr_en && seg_wr_idx == seg_sel) ##1 (seg_sel == $past(seg_sel))
      |-> sel_seg == $past(seg_wr_data));

  p_gate_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gate_wr_en |=> gate_q == $past(gate_wr_val));

  p_gate_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_wr_en |=> $stable(gate_q));
endmodule

bind segaddr_unit segaddr_unit_chk #(
  .SEG_W(SEG_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .SUM_W(SUM_W), .BUS_W(BUS_W)
) chk_i (.*);

// File: tb/segaddr_unit_tb_top.sv
module segaddr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seg_wr_en = 1'b0;
  logic [1:0]  seg_wr_idx = 2'd0;
  logic [15:0] seg_wr_data = 16'h0;
  logic        gate_wr_en = 1'b0;
  logic        gate_wr_val = 1'b0;
  logic [1:0]  seg_sel = 2'd0;
  logic [15:0] offset = 16'h0;
  logic [23:0] phys_addr;
  logic        hma_hit;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;
  logic [15:0] model [4];
  bit gate_m = 1'b0;

  always #4 clk = ~clk;

  segaddr_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_data(seg_wr_data),
    .gate_wr_en(gate_wr_en), .gate_wr_val(gate_wr_val),
    .seg_sel(seg_sel), .offset(offset),
    .phys_addr(phys_addr), .hma_hit(hma_hit)
  );

  function automatic logic [23:0] expect_addr(logic [15:0] s, logic [15:0] o, bit g);
    int unsigned v;
    v = s * 16 + o;
    if (!g) v = v % 32'h100000;
    return 24'(v);
  endfunction

  task automatic probe(string req, logic [1:0] sel, logic [15:0] off,
                       logic [23:0] exp_a);
    logic exp_h;
    seg_sel = sel;
    offset  = off;
    #1;
    exp_h = (exp_a >= 24'h100000);
    vectors++;
    if (phys_addr !== exp_a || hma_hit !== exp_h) begin
      errors++;
      $display("FAIL %s sel=%0d off=%h: addr=%h hma=%b expected addr=%h hma=%b",
               req, sel, off, phys_addr, hma_hit, exp_a, exp_h);
    end
  endtask

  task automatic write_seg(logic [1:0] idx, logic [15:0] val);
    @(negedge clk);
    seg_wr_en = 1'b1; seg_wr_idx = idx; seg_wr_data = val;
    @(negedge clk);
    seg_wr_en = 1'b0;
    model[idx] = val;
  endtask

  task automatic write_gate(bit en, bit val);
    @(negedge clk);
    gate_wr_en = en; gate_wr_val = val;
    @(negedge clk);
    gate_wr_en = 1'b0; gate_wr_val = 1'b0;
    if (en) gate_m = val;
  endtask

  task automatic check_all_segs(string req);
    for (int k = 0; k < 4; k++)
      probe(req, 2'(k), 16'h0, expect_addr(model[k], 16'h0, gate_m));
  endtask

  initial begin
    model[0] = 16'hFFFF; model[1] = 16'h0; model[2] = 16'h0; model[3] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state, gate closed so code segment FFFF wraps
    check_all_segs("R8");
    probe("R8/R4", 2'd0, 16'hFFFF, 24'h00FFEF);
    // R9: gate_wr_val without strobe has no effect
    write_gate(1'b0, 1'b1);
    probe("R9", 2'd0, 16'hFFFF, 24'h00FFEF);
    write_gate(1'b1, 1'b1);
    probe("R3", 2'd0, 16'hFFFF, 24'h10FFEF);
    probe("R5", 2'd0, 16'h0010, 24'h100000);
    probe("R5", 2'd0, 16'h000F, 24'h0FFFFF);
    // R2: worked example on the data register
    write_seg(2'd1, 16'h07C0);
    probe("R2", 2'd1, 16'h0007, 24'h007C07);
    // R6/R7: distinct values per register, others kept
    write_seg(2'd0, 16'h1111);
    write_seg(2'd2, 16'h2222);
    write_seg(2'd3, 16'h3333);
    check_all_segs("R6");
    write_seg(2'd2, 16'hABCD);
    check_all_segs("R7");
    write_gate(1'b1, 1'b0);
    probe("R4", 2'd2, 16'hFFFF, expect_addr(16'hABCD, 16'hFFFF, 1'b0));
    // R1/R4/R5/R10: sweep of segments and offsets under both gate states
    for (int g = 0; g < 2; g++) begin
      write_gate(1'b1, g[0]);
      for (int s = 0; s < 65536; s += 257) begin
        write_seg(2'(s % 4), 16'(s));
        probe("R7", 2'((s + 1) % 4), 16'h0,
              expect_addr(model[(s + 1) % 4], 16'h0, gate_m));
        for (int o = 0; o < 65536; o += 1021)
          probe(g ? "R1" : "R4", 2'(s % 4), 16'(o), expect_addr(16'(s), 16'(o), gate_m));
        probe(g ? "R1" : "R4", 2'(s % 4), 16'hFFFF,
              expect_addr(16'(s), 16'hFFFF, gate_m));
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule